// File: doc/BRIEF.md
# Word-to-Line Memory Request Translator

This block joins a processor's word-wide memory port to a memory that is 512 bits wide and addressed by whole lines. It holds no data. Every CPU access becomes exactly one wide-memory access. A CPU request carries a byte address and, for a store, a 32-bit word.

A load goes out as a line read. The translator records which of the 16 words in the line the load wants. When the line comes back, perhaps many cycles later, it returns only that 32-bit slice to the CPU. A store goes out as a partial line write: the 32-bit word is placed at its slot in the 512-bit data, and only its four byte enables are raised. Stores get no response.

Both sides use valid/ready handshakes. The request path and the response path are combinational, so the block adds no cycles of latency. The only sequential state is a small in-order queue of word offsets, one entry for each load that has been sent out and not yet answered.

Top module: `word_line_xlate`

## Requirements
- R1: After reset no load is pending. With memory ready and no CPU request, `mem_req_valid` and `cpu_rsp_valid` are low and `cpu_req_ready` is high.
- R2: The wide-memory address is the CPU byte address shifted right by 6, so it is bits [29:6], 24 bits wide.
- R3: A load goes out with `mem_req_write` low and all 64 byte enables low.
- R4: A store goes out with `mem_req_write` high. With k = address bits [5:2], only byte-enable bits 4k to 4k+3 are set. The store word sits at data bits [32k+31:32k], and every other data bit is zero.
- R5: A store produces no CPU response and takes no offset queue slot. A store is accepted even while the queue is full.
- R6: The CPU response data is bits [32k+31:32k] of the returned line, where k is the word offset recorded for the oldest pending load.
- R7: Several outstanding loads with different offsets are answered in issue order, each with its own offset.
- R8: At most DEPTH (default 4) loads may be pending. While DEPTH loads are pending, `cpu_req_ready` is low for a load until a response is consumed.
- R9: `cpu_req_ready` follows `mem_req_ready`, and `mem_rsp_ready` follows `cpu_rsp_ready`. The recorded offset is not consumed while the CPU stalls the response.
- R10: Address bits [1:0] do not affect the request or the word selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_ready | output | 1 | CPU request accepted this cycle |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | CPU byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | Load data valid |
| cpu_rsp_ready | input | 1 | CPU takes the load data |
| cpu_rsp_data | output | 32 | Selected word of the returned line |
| mem_req_valid | output | 1 | Wide request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = line write |
| mem_req_addr | output | 24 | Line address |
| mem_req_be | output | 64 | Byte enables, one per byte |
| mem_req_wdata | output | 512 | Line write data |
| mem_rsp_valid | input | 1 | Line read data valid |
| mem_rsp_ready | output | 1 | Translator takes the line |
| mem_rsp_data | input | 512 | Returned line |

## Verification
Both translation paths are combinational, so every request field and every response word is due in the same cycle as the stimulus that causes it. The bench drives inputs just after a falling edge and samples a short delay later, still before the rising edge that completes the handshake. The offset queue changes only at that rising edge. For this reason the ready level that depends on queue occupancy (R8) is checked in the cycle after the load or response that changed it.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int CPU_AW     = 32;
    localparam int WORD_W     = 32;
    localparam int LINE_W     = 512;
    localparam int MEM_AW     = 24;
    localparam int WORDS      = LINE_W / WORD_W;
    localparam int OFF_W      = $clog2(WORDS);
    localparam int BE_W       = LINE_W / 8;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int BYTE_LSB   = $clog2(WORD_BYTES);
    localparam int LINE_LSB   = $clog2(BE_W);

    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [BE_W-1:0]   be_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic                write;
        logic [MEM_AW-1:0]   addr;
        be_t                 be;
        line_t               data;
    } wide_req_t;

    function automatic logic [MEM_AW-1:0] line_of(input logic [CPU_AW-1:0] a);
        return a[LINE_LSB +: MEM_AW];
    endfunction

    function automatic off_t off_of(input logic [CPU_AW-1:0] a);
        return a[BYTE_LSB +: OFF_W];
    endfunction

    function automatic be_t word_mask(input off_t k);
        be_t m;
        m = '0;
        m[k*WORD_BYTES +: WORD_BYTES] = '1;
        return m;
    endfunction

    function automatic line_t spread(input off_t k, input word_t d);
        line_t l;
        l = '0;
        l[k*WORD_W +: WORD_W] = d;
        return l;
    endfunction

    function automatic word_t pick(input line_t l, input off_t k);
        return l[k*WORD_W +: WORD_W];
    endfunction
endpackage

// File: rtl/xlate_off_queue.sv
module xlate_off_queue
    import xlate_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  off_t             din,
    input  logic             pop,
    output off_t             dout,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    off_t             slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign dout  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= din;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/xlate_req_encode.sv
module xlate_req_encode
    import xlate_pkg::*;
(
    input  logic              write,
    input  logic [CPU_AW-1:0] addr,
    input  word_t             wdata,
    output wide_req_t         req,
    output off_t              off
);
    always_comb begin
        off       = off_of(addr);
        req.write = write;
        req.addr  = line_of(addr);
        req.be    = write ? word_mask(off) : '0;
        req.data  = write ? spread(off, wdata) : '0;
    end
endmodule

// File: rtl/xlate_rsp_select.sv
module xlate_rsp_select
    import xlate_pkg::*;
(
    input  line_t line,
    input  off_t  off,
    output word_t word
);
    assign word = pick(line, off);
endmodule

// File: rtl/word_line_xlate.sv
module word_line_xlate
    import xlate_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req_valid,
    output logic          cpu_req_ready,
    input  logic          cpu_req_write,
    input  logic [31:0]   cpu_req_addr,
    input  logic [31:0]   cpu_req_wdata,
    output logic          cpu_rsp_valid,
    input  logic          cpu_rsp_ready,
    output logic [31:0]   cpu_rsp_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [23:0]   mem_req_addr,
    output logic [63:0]   mem_req_be,
    output logic [511:0]  mem_req_wdata,
    input  logic          mem_rsp_valid,
    output logic          mem_rsp_ready,
    input  logic [511:0]  mem_rsp_data
);
    wide_req_t        enc;
    off_t             enc_off, head_off;
    logic             q_full, q_empty, slot_ok, push, pop;
    logic [CNT_W-1:0] q_count;

    xlate_req_encode u_enc (
        .write (cpu_req_write),
        .addr  (cpu_req_addr),
        .wdata (cpu_req_wdata),
        .req   (enc),
        .off   (enc_off)
    );

    // loads need a queue slot, stores do not
    assign slot_ok       = cpu_req_write || !q_full;
    assign mem_req_valid = cpu_req_valid && slot_ok;
    assign cpu_req_ready = mem_req_ready && slot_ok;
    assign mem_req_write = enc.write;
    assign mem_req_addr  = enc.addr;
    assign mem_req_be    = enc.be;
    assign mem_req_wdata = enc.data;

    assign push = cpu_req_valid && cpu_req_ready && !cpu_req_write;
    assign pop  = mem_rsp_valid && cpu_rsp_ready;

    xlate_off_queue #(.DEPTH(DEPTH)) u_q (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (enc_off),
        .pop   (pop),
        .dout  (head_off),
        .full  (q_full),
        .empty (q_empty),
        .count (q_count)
    );

    xlate_rsp_select u_sel (
        .line (mem_rsp_data),
        .off  (head_off),
        .word (cpu_rsp_data)
    );

    assign cpu_rsp_valid = mem_rsp_valid;
    assign mem_rsp_ready = cpu_rsp_ready;
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_req_valid,
    input logic             cpu_req_ready,
    input logic             cpu_req_write,
    input logic [31:0]      cpu_req_addr,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic             mem_req_write,
    input logic [23:0]      mem_req_addr,
    input logic [63:0]      mem_req_be,
    input logic             mem_rsp_valid,
    input logic [CNT_W-1:0] q_count
);
    a_r2_line_addr: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_addr == cpu_req_addr[29:6]);
    a_r3_read_no_be: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_write) |-> mem_req_be == 64'd0);
    a_r4_four_bytes: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> $countones(mem_req_be) == 4);
    a_r9_accept_forwards: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && cpu_req_ready) |-> (mem_req_valid && mem_req_ready));
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        q_count <= CNT_W'(DEPTH));
    a_r8_load_gated: assert property (@(posedge clk) disable iff (rst)
        (q_count == CNT_W'(DEPTH) && cpu_req_valid && !cpu_req_write) |-> !cpu_req_ready);
    a_r6_rsp_has_owner: assert property (@(posedge clk) disable iff (rst)
        mem_rsp_valid |-> q_count != '0);
endmodule

bind word_line_xlate xlate_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_write (cpu_req_write),
    .cpu_req_addr  (cpu_req_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_be    (mem_req_be),
    .mem_rsp_valid (mem_rsp_valid),
    .q_count       (q_count)
);

// File: tb/sim_word_line_xlate.sv
module sim_word_line_xlate;
    logic clk = 0, rst = 1;
    logic cpu_req_valid = 0, cpu_req_write = 0, cpu_rsp_ready = 1;
    logic [31:0] cpu_req_addr = 0, cpu_req_wdata = 0;
    logic mem_req_ready = 1, mem_rsp_valid = 0;
    logic [511:0] mem_rsp_data = 0;
    logic cpu_req_ready, cpu_rsp_valid, mem_req_valid, mem_req_write, mem_rsp_ready;
    logic [31:0] cpu_rsp_data;
    logic [23:0] mem_req_addr;
    logic [63:0] mem_req_be;
    logic [511:0] mem_req_wdata;
    int runs = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    word_line_xlate u0 (.*);

    // table entries: {write, addr, wdata}
    localparam logic [64:0] VEC [6] = '{
        {1'b0, 32'h0000_0000, 32'h0},
        {1'b0, 32'h0000_127C, 32'h0},
        {1'b1, 32'h0001_0044, 32'hCAFE_F00D},
        {1'b0, 32'h00AB_CD2B, 32'h0},
        {1'b1, 32'h3FFF_FFFF, 32'h1234_5678},
        {1'b1, 32'hC000_0003, 32'hA5A5_5A5A}
    };

    function automatic logic [511:0] mk_line(input logic [23:0] tag);
        logic [511:0] l;
        for (int i = 0; i < 16; i++) l[i*32 +: 32] = {tag, 4'h0, 4'(i)};
        return l;
    endfunction

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic w, input logic [31:0] a, input logic [31:0] d);
        logic [3:0] k;
        logic [63:0] be;
        logic [511:0] wd;
        k = a[5:2];
        be = '0; wd = '0;
        if (w) begin be[k*4 +: 4] = 4'hF; wd[k*32 +: 32] = d; end
        @(negedge clk);
        cpu_req_valid = 1; cpu_req_write = w; cpu_req_addr = a; cpu_req_wdata = d;
        #2;
        chk("R2", mem_req_addr, a[29:6]);
        chk(w ? "R4" : "R3", {mem_req_write, mem_req_be}, {w, be});
        if (w) chk("R4", mem_req_wdata, wd);
        @(posedge clk); #1;
        cpu_req_valid = 0;
    endtask

    task automatic answer(input logic [23:0] tag, input logic [3:0] k, input string req);
        @(negedge clk);
        mem_rsp_valid = 1; mem_rsp_data = mk_line(tag);
        #2;
        chk(req, {cpu_rsp_valid, cpu_rsp_data}, {1'b1, tag, 4'h0, k});
        @(posedge clk); #1;
        mem_rsp_valid = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R1", {mem_req_valid, cpu_rsp_valid, cpu_req_ready}, 3'b001);

        for (int i = 0; i < 6; i++) begin
            issue(VEC[i][64], VEC[i][63:32], VEC[i][31:0]);
            if (!VEC[i][64]) answer(VEC[i][55:32], VEC[i][37:34], "R6");
        end
        // R10: low two address bits do not change the word
        issue(0, 32'h0000_0047, 0);
        answer(24'h000001, 4'h1, "R10");

        // R7: three outstanding loads answered in order
        issue(0, 32'h0000_008C, 0);
        issue(0, 32'h0000_00FC, 0);
        issue(0, 32'h0000_0100, 0);
        answer(24'h000002, 4'h3, "R7");
        answer(24'h000003, 4'hF, "R7");
        answer(24'h000004, 4'h0, "R7");

        // R8: fill four slots, loads blocked, store still accepted (R5)
        for (int i = 0; i < 4; i++) issue(0, 32'h40 * i + 32'h8, 0);
        @(negedge clk);
        cpu_req_valid = 1; cpu_req_write = 0; #2;
        chk("R8", {cpu_req_ready, mem_req_valid}, 2'b00);
        cpu_req_write = 1; #1;
        chk("R5", {cpu_req_ready, mem_req_valid}, 2'b11);
        @(posedge clk); #1 cpu_req_valid = 0;
        @(negedge clk); #2;
        chk("R5", cpu_rsp_valid, 1'b0);

        // R9: stalled response keeps the oldest offset
        cpu_rsp_ready = 0; mem_rsp_valid = 1; mem_rsp_data = mk_line(24'h000000);
        #1 chk("R9", mem_rsp_ready, 1'b0);
        @(posedge clk); #1;
        cpu_rsp_ready = 1; mem_rsp_valid = 0;
        answer(24'h000000, 4'h2, "R9");
        @(negedge clk);
        cpu_req_valid = 1; cpu_req_write = 0; #2;
        chk("R8", cpu_req_ready, 1'b1);
        mem_req_ready = 0; #1;
        chk("R9", cpu_req_ready, 1'b0);
        cpu_req_valid = 0; mem_req_ready = 1;
        answer(24'h000001, 4'h2, "R7");
        answer(24'h000002, 4'h2, "R7");
        answer(24'h000003, 4'h2, "R7");

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1; runs++; fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  [TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end
endmodule